// File: doc/BRIEF.md
# Indexed Clock Register Port

This block is the host-facing front end of a real-time clock. The host reaches every location through one index/data pair. It first writes a location number to the index port. It then reads or writes the data port, and that access lands on the indexed location. The index stays in place until the next index write, so a run of accesses to one location needs a single index write.

The block decodes the index into five kinds of location. Ten timekeeping locations (time of day and alarm) are passed through to a separate counting block. Two control bytes are held here. An interrupt flag byte is read-only and clears when it is read. A fixed status byte reports that the time and storage are valid. A 50-byte general-purpose storage window follows. Counting the time, generating interrupt rates and detecting battery loss are left to other blocks. The counting block reports its events on three single-cycle event inputs and its update-in-progress state on a level input.

Top module: `rtc_index_port`

## Requirements
- R1: A one-cycle pulse on `host_addr_we` stores all 8 bits of `host_wdata` as the current index. Every later data access uses that index until the next index write.
- R2: Indices 0 to 9 are timekeeping locations. A data write there pulses `tk_we` in the same cycle, with `tk_idx` equal to the index and `tk_wdata` equal to the written byte. A data read there returns `tk_rdata`.
- R3: Index 10 is control byte A. Bits 6:0 are read/write and appear on `ctrl_a`. Bit 7 reads the `uip_in` input as sampled at the read strobe, and host writes to bit 7 are ignored.
- R4: Index 11 is control byte B. All 8 bits are read/write and appear on `ctrl_b`. Bits 4, 5 and 6 enable the update, alarm and periodic interrupts.
- R5: Index 12 reads as the flag byte: bit 4 update flag, bit 5 alarm flag, bit 6 periodic flag, bit 7 request flag, bits 3:0 zero. A pulse on `evt_update`, `evt_alarm` or `evt_periodic` sets the matching flag. The request flag, which is also the `irq` output, is 1 whenever a set flag has its enable bit set in control byte B.
- R6: The flag byte is read-only, and writes to it have no effect. A data read of it returns the flags held before the read and clears them all in the same edge. An event arriving in that same cycle still sets its flag.
- R7: Index 13 always reads 0x80 (time and storage valid, other bits zero), and writes to it have no effect.
- R8: Indices 14 to 63 are 50 bytes of read/write storage. Index 14 is byte 0.
- R9: Indices 64 to 255 read as 0x00. A data write there changes no location and does not pulse `tk_we`.
- R10: After a synchronous active-low reset, `host_rvalid`, `host_rdata`, `ctrl_a`, `ctrl_b`, `irq` and all flags are zero. The storage bytes keep their contents.
- R11: A one-cycle `host_data_re` pulse presents the read byte on `host_rdata` with `host_rvalid` high in the following cycle. `host_rvalid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr_we | input | 1 | Index port write strobe |
| host_data_we | input | 1 | Data port write strobe |
| host_data_re | input | 1 | Data port read strobe |
| host_wdata | input | 8 | Host write byte (index or data) |
| host_rdata | output | 8 | Read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read result valid |
| tk_idx | output | 4 | Timekeeping location selected by the index |
| tk_we | output | 1 | Timekeeping write pulse |
| tk_wdata | output | 8 | Timekeeping write byte |
| tk_rdata | input | 8 | Timekeeping byte at tk_idx |
| uip_in | input | 1 | Update-in-progress level from the counter |
| evt_update | input | 1 | Update-end event pulse |
| evt_alarm | input | 1 | Alarm match event pulse |
| evt_periodic | input | 1 | Periodic tick event pulse |
| ctrl_a | output | 7 | Writable bits of control byte A |
| ctrl_b | output | 8 | Control byte B |
| irq | output | 1 | Interrupt request (flag byte bit 7) |

## Verification
A random mix of index writes, data writes and data reads covers every decode region, including indices above the window. Every read is compared against a bench model of each location. This separates misrouted decodes, lost writes and aliasing between the storage window and the timekeeping locations. Directed sequences then toggle the update-in-progress input and write all-ones to read-only bits, which shows whether read-only bits are held apart from writable ones. Event pulses are issued with the interrupt enables both off and on, and one event arrives in the same cycle as a clearing read. These cases distinguish correct clear-on-read ordering from a lost event or a stale request line.

// File: rtl/rtc_port_pkg.sv
// Package: shared decode kinds and flag bit positions for the indexed
// clock register port. Assumes an 8-bit data path.
package rtc_port_pkg;
    localparam int BYTE_W   = 8;
    // Flag byte bit positions; control byte B uses the same positions for
    // the matching interrupt enables.
    localparam int FLG_UPD  = 4;
    localparam int FLG_ALM  = 5;
    localparam int FLG_PER  = 6;
    localparam int FLG_REQ  = 7;
    localparam logic [BYTE_W-1:0] STATUS_VALID = 8'h80;

    typedef enum logic [2:0] {
        SEL_TK,
        SEL_CA,
        SEL_CB,
        SEL_FLAGS,
        SEL_STATUS,
        SEL_RAM,
        SEL_NONE
    } loc_sel_e;
endpackage

// File: rtl/rtc_ctrl_regs.sv
// Module: control bytes A and B. A stores only its seven writable bits; its
// top bit is supplied elsewhere. Assumes one write strobe per byte.
module rtc_ctrl_regs
    import rtc_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_a,
    input  logic              we_b,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-2:0] ctrl_a,
    output logic [BYTE_W-1:0] ctrl_b
);
    // Load control byte A (bit 7 discarded) on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctrl_a <= '0;
        else if (we_a) ctrl_a <= wdata[BYTE_W-2:0];
    end

    // Load control byte B on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctrl_b <= '0;
        else if (we_b) ctrl_b <= wdata;
    end
endmodule

// File: rtl/rtc_flag_reg.sv
// Module: interrupt flag byte. Events set flags. A clearing read empties them,
// but an event in the same cycle wins over the clear. The request output is
// the OR of the enabled flags. Assumes event inputs are single-cycle pulses.
module rtc_flag_reg
    import rtc_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        evt,      // {periodic, alarm, update}
    input  logic [2:0]        en,       // enables, same order
    input  logic              rd_clr,
    output logic [BYTE_W-1:0] rd_val,
    output logic              irq
);
    logic [2:0] flags_q;

    // Hold flags: clear on read, then OR in this cycle's events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd_clr ? 3'b000 : flags_q) | evt;
    end

    // Request line and readable byte image.
    always_comb begin
        irq    = |(flags_q & en);
        rd_val = '0;
        rd_val[FLG_REQ]           = irq;
        rd_val[FLG_PER:FLG_UPD]   = flags_q;
    end
endmodule

// File: rtl/rtc_nvram.sv
// Module: general-purpose byte storage with synchronous write and
// combinational read. Not reset: contents model battery-backed storage.
module rtc_nvram
    import rtc_port_pkg::*;
#(
    parameter int DEPTH = 50,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem [DEPTH];

    // Store a byte on write.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Read the addressed byte.
    assign rdata = mem[addr];
endmodule

// File: rtl/rtc_index_port.sv
// Module: indexed host port of a real-time clock. Latches an index from the
// host, decodes it into timekeeping, control, flag, status, storage or empty
// regions, routes data writes and returns registered read data one cycle
// after a read strobe. Assumes at most one host strobe per cycle.
module rtc_index_port
    import rtc_port_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int TK_COUNT  = 10,
    parameter int RAM_DEPTH = 50,
    localparam int TK_IDX_W = $clog2(TK_COUNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_addr_we,
    input  logic                host_data_we,
    input  logic                host_data_re,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [BYTE_W-1:0]   host_rdata,
    output logic                host_rvalid,
    output logic [TK_IDX_W-1:0] tk_idx,
    output logic                tk_we,
    output logic [BYTE_W-1:0]   tk_wdata,
    input  logic [BYTE_W-1:0]   tk_rdata,
    input  logic                uip_in,
    input  logic                evt_update,
    input  logic                evt_alarm,
    input  logic                evt_periodic,
    output logic [BYTE_W-2:0]   ctrl_a,
    output logic [BYTE_W-1:0]   ctrl_b,
    output logic                irq
);
    localparam int IDX_CA   = TK_COUNT;
    localparam int IDX_CB   = TK_COUNT + 1;
    localparam int IDX_FLG  = TK_COUNT + 2;
    localparam int IDX_STS  = TK_COUNT + 3;
    localparam int RAM_BASE = TK_COUNT + 4;
    localparam int RAM_END  = RAM_BASE + RAM_DEPTH;
    localparam int RAM_AW   = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

    logic [IDX_W-1:0]  idx_q;
    loc_sel_e          sel;
    logic [BYTE_W-1:0] rd_mux;
    logic [BYTE_W-1:0] flag_val;
    logic [BYTE_W-1:0] ram_rdata;
    logic [RAM_AW-1:0] ram_addr;
    logic              ram_we;

    // Latch the index from the host.
    always_ff @(posedge clk) begin
        if (!rst_n)            idx_q <= '0;
        else if (host_addr_we) idx_q <= IDX_W'(host_wdata);
    end

    // Decode the current index into a region.
    always_comb begin
        if (idx_q < IDX_W'(TK_COUNT))        sel = SEL_TK;
        else if (idx_q == IDX_W'(IDX_CA))    sel = SEL_CA;
        else if (idx_q == IDX_W'(IDX_CB))    sel = SEL_CB;
        else if (idx_q == IDX_W'(IDX_FLG))   sel = SEL_FLAGS;
        else if (idx_q == IDX_W'(IDX_STS))   sel = SEL_STATUS;
        else if (idx_q < IDX_W'(RAM_END))    sel = SEL_RAM;
        else                                 sel = SEL_NONE;
    end

    // Route timekeeping accesses straight through.
    assign tk_idx   = idx_q[TK_IDX_W-1:0];
    assign tk_we    = host_data_we && (sel == SEL_TK);
    assign tk_wdata = host_wdata;

    rtc_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_a   (host_data_we && (sel == SEL_CA)),
        .we_b   (host_data_we && (sel == SEL_CB)),
        .wdata  (host_wdata),
        .ctrl_a (ctrl_a),
        .ctrl_b (ctrl_b)
    );

    rtc_flag_reg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    ({evt_periodic, evt_alarm, evt_update}),
        .en     (ctrl_b[FLG_PER:FLG_UPD]),
        .rd_clr (host_data_re && (sel == SEL_FLAGS)),
        .rd_val (flag_val),
        .irq    (irq)
    );

    // Storage offset and write strobe.
    assign ram_addr = RAM_AW'(idx_q - IDX_W'(RAM_BASE));
    assign ram_we   = host_data_we && (sel == SEL_RAM);

    generate
        if (RAM_DEPTH > 0) begin : g_ram
            rtc_nvram #(.DEPTH(RAM_DEPTH)) u_ram (
                .clk   (clk),
                .we    (ram_we),
                .addr  (ram_addr),
                .wdata (host_wdata),
                .rdata (ram_rdata)
            );
        end else begin : g_no_ram
            assign ram_rdata = '0;
        end
    endgenerate

    // Select the byte image of the indexed location.
    always_comb begin
        unique case (sel)
            SEL_TK:     rd_mux = tk_rdata;
            SEL_CA:     rd_mux = {uip_in, ctrl_a};
            SEL_CB:     rd_mux = ctrl_b;
            SEL_FLAGS:  rd_mux = flag_val;
            SEL_STATUS: rd_mux = STATUS_VALID;
            SEL_RAM:    rd_mux = ram_rdata;
            default:    rd_mux = '0;
        endcase
    end

    // Register the read byte and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_data_re;
            if (host_data_re) host_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/rtc_index_port_chk.sv
// Module: property checker for the indexed clock register port, attached to
// every instance by the bind below. Observes ports and the held index.
module rtc_index_port_chk #(
    parameter int IDX_W     = 8,
    parameter int TK_COUNT  = 10,
    parameter int RAM_DEPTH = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] idx_q,
    input logic             host_data_we,
    input logic             host_data_re,
    input logic [7:0]       host_rdata,
    input logic             host_rvalid,
    input logic             tk_we,
    input logic             uip_in,
    input logic             evt_update,
    input logic             evt_alarm,
    input logic             evt_periodic,
    input logic             irq
);
    localparam int IDX_CA  = TK_COUNT;
    localparam int IDX_FLG = TK_COUNT + 2;
    localparam int IDX_STS = TK_COUNT + 3;
    localparam int RAM_END = TK_COUNT + 4 + RAM_DEPTH;

    p_tk_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tk_we |-> (idx_q < IDX_W'(TK_COUNT)) && host_data_we);

    p_uip_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_re && idx_q == IDX_W'(IDX_CA)) |=> host_rdata[7] == $past(uip_in));

    p_flag_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_re && idx_q == IDX_W'(IDX_FLG)) |=> host_rdata[3:0] == 4'h0);

    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_re && idx_q == IDX_W'(IDX_FLG) && !evt_update && !evt_alarm && !evt_periodic)
        |=> !irq);

    p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_re && idx_q == IDX_W'(IDX_STS)) |=> host_rdata == 8'h80);

    p_outside_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_re && idx_q >= IDX_W'(RAM_END)) |=> host_rdata == 8'h00);

    p_rvalid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_data_re |=> host_rvalid);

    p_rvalid_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_data_re |=> !host_rvalid);
endmodule

bind rtc_index_port rtc_index_port_chk #(
    .IDX_W(IDX_W), .TK_COUNT(TK_COUNT), .RAM_DEPTH(RAM_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idx_q        (idx_q),
    .host_data_we (host_data_we),
    .host_data_re (host_data_re),
    .host_rdata   (host_rdata),
    .host_rvalid  (host_rvalid),
    .tk_we        (tk_we),
    .uip_in       (uip_in),
    .evt_update   (evt_update),
    .evt_alarm    (evt_alarm),
    .evt_periodic (evt_periodic),
    .irq          (irq)
);

// File: tb/test_rtc_index_port.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random access mix, checked
// against bench-side expected values for every location.
module test_rtc_index_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_addr_we = 0, host_data_we = 0, host_data_re = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic [3:0] tk_idx;
    logic       tk_we;
    logic [7:0] tk_wdata;
    logic [7:0] tk_rdata;
    logic       uip_in = 0, evt_update = 0, evt_alarm = 0, evt_periodic = 0;
    logic [6:0] ctrl_a;
    logic [7:0] ctrl_b;
    logic       irq;

    int n_tests = 0, n_fail = 0, stray_tk = 0;
    bit done = 0;

    // Bench model of the external timekeeping block.
    logic [7:0] tk_mem [16];
    // Expected state.
    logic [7:0] exp_tk [10];
    logic [7:0] exp_ram [50];
    logic [6:0] exp_a;
    logic [7:0] exp_b;
    logic [7:0] cur_idx = 0;

    always #2.5 clk = ~clk;

    rtc_index_port i_rtc_index_port (.*);

    initial for (int k = 0; k < 16; k++) tk_mem[k] = 8'h00;
    always @(posedge clk) if (tk_we) tk_mem[tk_idx] <= tk_wdata;
    assign tk_rdata = tk_mem[tk_idx];
    always @(posedge clk) if (rst_n && tk_we && cur_idx >= 8'd10) stray_tk++;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] i);
        @(negedge clk); host_addr_we = 1; host_wdata = i;
        @(negedge clk); host_addr_we = 0; cur_idx = i;
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] d);
        set_idx(i);
        @(negedge clk); host_data_we = 1; host_wdata = d;
        @(negedge clk); host_data_we = 0;
        if (i < 10)                exp_tk[i] = d;
        else if (i == 10)          exp_a = d[6:0];
        else if (i == 11)          exp_b = d;
        else if (i >= 14 && i < 64) exp_ram[i-14] = d;
    endtask

    // Read byte; rvalid must be high in the cycle after the strobe (R11).
    task automatic rd(input logic [7:0] i, output logic [7:0] v);
        set_idx(i);
        @(negedge clk); host_data_re = 1;
        @(negedge clk); host_data_re = 0;
        v = host_rdata;
        check("R11 rvalid", {7'b0, host_rvalid}, 8'h01);
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] i, input logic u);
        if (i < 10)       return exp_tk[i];
        else if (i == 10) return {u, exp_a};
        else if (i == 11) return exp_b;
        else if (i == 12) return 8'h00;
        else if (i == 13) return 8'h80;
        else if (i < 64)  return exp_ram[i-14];
        else              return 8'h00;
    endfunction

    function automatic logic [7:0] pick_idx(input int r);
        case (r % 8)
            0, 1:    return 8'($urandom_range(0, 9));
            2:       return 8'd10;
            3:       return 8'd11;
            4:       return 8'($urandom_range(12, 13));
            5, 6:    return 8'($urandom_range(14, 63));
            default: return 8'($urandom_range(64, 255));
        endcase
    endfunction

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 10; k++) exp_tk[k] = 8'h00;
        exp_a = 0; exp_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check("R10 rdata", host_rdata, 8'h00);
        check("R10 rvalid", {7'b0, host_rvalid}, 8'h00);
        check("R10 ctrl_a", {1'b0, ctrl_a}, 8'h00);
        check("R10 ctrl_b", ctrl_b, 8'h00);
        check("R10 irq", {7'b0, irq}, 8'h00);
        rd(8'd12, v); check("R10 flags", v, 8'h00);

        // R8: fill and read back storage
        for (int k = 14; k < 64; k++) wr(8'(k), 8'(k * 7 + 3));
        for (int k = 14; k < 64; k++) begin rd(8'(k), v); check("R8 storage", v, 8'(k * 7 + 3)); end

        // R2: timekeeping routing
        for (int k = 0; k < 10; k++) wr(8'(k), 8'(8'hA0 + k));
        for (int k = 0; k < 10; k++) begin rd(8'(k), v); check("R2 timekeeping", v, 8'(8'hA0 + k)); end
        check("R2 tk model", tk_mem[9], 8'hA9);

        // R3: bit 7 of A follows uip_in, writes to it ignored
        wr(8'd10, 8'hFF);
        check("R3 ctrl_a", {1'b0, ctrl_a}, 8'h7F);
        uip_in = 0; rd(8'd10, v); check("R3 A uip low", v, 8'h7F);
        uip_in = 1; rd(8'd10, v); check("R3 A uip high", v, 8'hFF);
        uip_in = 0;

        // R4: control byte B
        wr(8'd11, 8'h5A); rd(8'd11, v); check("R4 B read", v, 8'h5A);
        check("R4 ctrl_b", ctrl_b, 8'h5A);
        wr(8'd11, 8'h00);

        // R7: status byte fixed
        wr(8'd13, 8'h00); rd(8'd13, v); check("R7 status", v, 8'h80);

        // R5/R6: flags with enables off
        @(negedge clk); evt_update = 1; @(negedge clk); evt_update = 0;
        check("R5 irq disabled", {7'b0, irq}, 8'h00);
        wr(8'd12, 8'hFF);
        rd(8'd12, v); check("R6 write ignored, R5 update flag", v, 8'h10);
        rd(8'd12, v); check("R6 cleared by read", v, 8'h00);
        // Enabled update interrupt
        wr(8'd11, 8'h10);
        @(negedge clk); evt_update = 1; evt_alarm = 1; @(negedge clk); evt_update = 0; evt_alarm = 0;
        check("R5 irq enabled", {7'b0, irq}, 8'h01);
        rd(8'd12, v); check("R5 flag byte", v, 8'hB0);
        check("R6 irq after read", {7'b0, irq}, 8'h00);
        // Periodic flag, then event in the clearing cycle
        wr(8'd11, 8'h60);
        @(negedge clk); evt_periodic = 1; @(negedge clk); evt_periodic = 0;
        set_idx(8'd12);
        @(negedge clk); host_data_re = 1; evt_alarm = 1;
        @(negedge clk); host_data_re = 0; evt_alarm = 0;
        check("R6 value before clear", host_rdata, 8'hC0);
        check("R6 event kept irq", {7'b0, irq}, 8'h01);
        rd(8'd12, v); check("R6 event kept", v, 8'hA0);
        wr(8'd11, 8'h00);

        // R9: outside window
        wr(8'd78, 8'h33);
        rd(8'd78, v); check("R9 outside read", v, 8'h00);
        rd(8'd14, v); check("R9 no alias", v, exp_ram[0]);
        rd(8'd0, v);  check("R9 tk untouched", v, exp_tk[0]);

        // R1: index held across accesses
        set_idx(8'd20);
        @(negedge clk); host_data_we = 1; host_wdata = 8'h11; @(negedge clk); host_data_we = 0;
        @(negedge clk); host_data_re = 1; @(negedge clk); host_data_re = 0;
        exp_ram[6] = 8'h11;
        check("R1 index held", host_rdata, 8'h11);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0] i;
            i = pick_idx(int'($urandom));
            uip_in = 1'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (i == 8'd11) d[6:4] = 3'b000;
                wr(i, d);
            end else begin
                rd(i, v);
                check("R1 random read", v, exp_read(i, uip_in));
            end
        end
        check("R9 stray timekeeping writes", 8'(stray_tk), 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule